// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the single-cycle entry into an exception handler. In the cycle a request is presented, it receives the exception source, the exception code, the PC of the faulting instruction, a flag saying whether that instruction sits in a branch delay slot, and the processor's current status bits. On the next clock edge it updates several registers: the return-address registers, the cause fields, the status image and, for address-translation faults, the fault-address registers. In that same cycle it raises a redirect strobe carrying the handler address that fetch must continue from.

There are three entry classes. A general entry saves into the exception PC and is gated by EXL. An error entry, for reset or non-maskable interrupt, saves into the error PC. A debug entry saves into the debug PC. For each class, the saved return address is rolled back one word when the faulting instruction is in a delay slot. For translation faults, the block picks the exception code from the fault kind and the access direction, and it formats the page-table context word and the translation high word from the faulting address. Decode, interrupt priority and the return instruction belong to the surrounding core.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A general entry (source 0, or source 1, or source 4 outside debug mode) taken with EXL clear does four things. It sets the exception PC to PC-4 with BD=1 when the delay-slot flag is set, and to PC with BD=0 otherwise. It then sets EXL and clears user mode.
- R2: A general entry taken while EXL is already set leaves the exception PC and BD unchanged. EXL stays set, user mode is cleared and the cause code is still written.
- R3: A general entry redirects to 0xBFC00200 when BEV is set. Otherwise it redirects to the exception base input with its low 10 bits forced to zero.
- R4: Source 0 writes the 5-bit code input into the cause code. Source 4 outside debug mode writes code 0.
- R5: Source 2 (reset or NMI) does the following:
  - sets the error PC using the R1 delay-slot rule;
  - sets ERL and BEV;
  - clears user mode;
  - clears BD if EXL is clear;
  - redirects to 0xBFC00000.
  The exception PC and cause code are untouched.
- R6: Source 3 (debug) does the following:
  - sets the debug PC using the R1 delay-slot rule;
  - sets debug mode;
  - clears user mode;
  - clears BD if EXL is clear;
  - redirects to 0xBFC00480.
- R7: Source 4 (external interrupt) arriving while debug mode is set is handled exactly as R6, and the cause code is left unchanged.
- R8: Source 1 takes its code from the fault kind. Kinds 0 (no match) and 1 (invalid) give code 3 for a write and code 2 for a read. Kind 2 (modify) gives code 1. Kind 3 (bad address) gives code 5 for a write and code 4 for a read.
- R9: Source 1 loads four values. The bad-address register takes the fault address. The context word becomes (base<<23) | ((addr>>9) & 0x007FFFF0). The translation high word becomes (addr & 0xFFFFE000) | ASID. No other source changes these registers.
- R10: The redirect strobe is high for exactly the cycle after an accepted request (sources 0 to 4). Source codes 5 to 7, or no request, produce no redirect and change no held register.
- R11: In a cycle with no entry, the status outputs take the status inputs one cycle later, and every held register keeps its value.
- R12: After reset, the redirect strobe, all held registers and EXL, user mode and debug mode are 0, and ERL and BEV are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req_i | input | 1 | Exception request this cycle |
| exc_src_i | input | 3 | Source: 0 general, 1 translation fault, 2 reset/NMI, 3 debug, 4 external interrupt |
| exc_code_i | input | 5 | Cause code for source 0 |
| fault_kind_i | input | 2 | Fault kind for source 1 |
| fault_wr_i | input | 1 | Faulting access was a write |
| fault_addr_i | input | 32 | Faulting virtual address |
| pc_i | input | 32 | PC of the faulting instruction |
| in_dslot_i | input | 1 | Faulting instruction is in a delay slot |
| exl_i | input | 1 | Current EXL |
| erl_i | input | 1 | Current ERL |
| bev_i | input | 1 | Current BEV |
| um_i | input | 1 | Current user mode |
| dm_i | input | 1 | Current debug mode |
| ebase_i | input | 32 | Exception base address |
| asid_i | input | 8 | Current address-space ID |
| ctx_base_i | input | 9 | Page-table base field of the context word |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Handler address |
| epc_o | output | 32 | Exception PC |
| errorepc_o | output | 32 | Error PC |
| depc_o | output | 32 | Debug PC |
| cause_bd_o | output | 1 | Cause delay-slot flag |
| cause_code_o | output | 5 | Cause exception code |
| exl_o | output | 1 | Updated EXL |
| erl_o | output | 1 | Updated ERL |
| bev_o | output | 1 | Updated BEV |
| um_o | output | 1 | Updated user mode |
| dm_o | output | 1 | Updated debug mode |
| badvaddr_o | output | 32 | Faulting address register |
| context_o | output | 32 | Page-table context word |
| entryhi_o | output | 32 | Translation high word |

## Verification
The bench aims at delay-slot rollback under all three entry classes. A design that skipped the rollback would return one instruction past the branch, and one that rolled back on the wrong register would corrupt a saved PC it should not touch. It also aims at entry with EXL already set, where overwriting the exception PC or BD would lose the first fault's return point. An external interrupt in debug mode must become a debug entry: a design that missed this would jump to the general vector and overwrite the cause code. The bench further covers every fault kind in both access directions, and the bit placement in the context and translation words. A shifted field there would hand the refill handler a wrong page-table slot.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN        = 32;
    localparam int ASID_W      = 8;
    localparam int CODE_W      = 5;
    localparam int PAGE_SHIFT  = 12;
    localparam int VPN2_LSB    = PAGE_SHIFT + 1;
    localparam int CTX_BASE_W  = 9;
    localparam int CTX_BASE_LSB = XLEN - CTX_BASE_W;
    localparam int CTX_SHIFT   = VPN2_LSB - 4;
    localparam int SRC_W       = 3;
    localparam int FKIND_W     = 2;
    localparam int EBASE_ALIGN = 10;
    localparam int INSN_BYTES  = 4;

    localparam logic [XLEN-1:0] VEC_ERROR   = 32'hBFC0_0000;
    localparam logic [XLEN-1:0] VEC_BOOTGEN = 32'hBFC0_0200;
    localparam logic [XLEN-1:0] VEC_DEBUG   = 32'hBFC0_0480;

    localparam logic [XLEN-1:0] VPN2_MASK  = {{(XLEN-VPN2_LSB){1'b1}}, {VPN2_LSB{1'b0}}};
    localparam logic [XLEN-1:0] CTX_MASK   = VPN2_MASK >> CTX_SHIFT & ~({CTX_BASE_W{1'b1}} << CTX_BASE_LSB);
    localparam logic [XLEN-1:0] ALIGN_MASK = {{(XLEN-EBASE_ALIGN){1'b1}}, {EBASE_ALIGN{1'b0}}};

    localparam logic [SRC_W-1:0] SRC_GENERAL = 3'd0;
    localparam logic [SRC_W-1:0] SRC_XLAT    = 3'd1;
    localparam logic [SRC_W-1:0] SRC_ERROR   = 3'd2;
    localparam logic [SRC_W-1:0] SRC_DEBUG   = 3'd3;
    localparam logic [SRC_W-1:0] SRC_EXTINT  = 3'd4;

    localparam logic [FKIND_W-1:0] FLT_NOMATCH = 2'd0;
    localparam logic [FKIND_W-1:0] FLT_INVALID = 2'd1;
    localparam logic [FKIND_W-1:0] FLT_MODIFY  = 2'd2;
    localparam logic [FKIND_W-1:0] FLT_BADADDR = 2'd3;

    localparam logic [CODE_W-1:0] CODE_INT  = 5'd0;
    localparam logic [CODE_W-1:0] CODE_MOD  = 5'd1;
    localparam logic [CODE_W-1:0] CODE_TLBL = 5'd2;
    localparam logic [CODE_W-1:0] CODE_TLBS = 5'd3;
    localparam logic [CODE_W-1:0] CODE_ADEL = 5'd4;
    localparam logic [CODE_W-1:0] CODE_ADES = 5'd5;

    typedef enum logic [1:0] {
        ENT_NONE,
        ENT_GENERAL,
        ENT_ERROR,
        ENT_DEBUG
    } entry_e;

    typedef struct packed {
        logic exl;
        logic erl;
        logic bev;
        logic um;
        logic dm;
    } status_t;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_pkg::*;
(
    input  logic               req_i,
    input  logic [SRC_W-1:0]   src_i,
    input  logic               dm_i,
    input  logic [CODE_W-1:0]  code_i,
    input  logic [FKIND_W-1:0] fkind_i,
    input  logic               fwr_i,
    output entry_e             entry_o,
    output logic               wr_code_o,
    output logic [CODE_W-1:0]  code_o,
    output logic               cap_fault_o
);
    logic [CODE_W-1:0] fault_code;

    always_comb begin
        unique case (fkind_i)
            FLT_NOMATCH,
            FLT_INVALID: fault_code = fwr_i ? CODE_TLBS : CODE_TLBL;
            FLT_MODIFY:  fault_code = CODE_MOD;
            default:     fault_code = fwr_i ? CODE_ADES : CODE_ADEL;
        endcase
    end

    always_comb begin
        entry_o     = ENT_NONE;
        wr_code_o   = 1'b0;
        code_o      = code_i;
        cap_fault_o = 1'b0;
        if (req_i) begin
            unique case (src_i)
                SRC_GENERAL: begin
                    entry_o   = ENT_GENERAL;
                    wr_code_o = 1'b1;
                end
                SRC_XLAT: begin
                    entry_o     = ENT_GENERAL;
                    wr_code_o   = 1'b1;
                    code_o      = fault_code;
                    cap_fault_o = 1'b1;
                end
                SRC_ERROR: entry_o = ENT_ERROR;
                SRC_DEBUG: entry_o = ENT_DEBUG;
                SRC_EXTINT: begin
                    if (dm_i) begin
                        entry_o = ENT_DEBUG;
                    end else begin
                        entry_o   = ENT_GENERAL;
                        wr_code_o = 1'b1;
                        code_o    = CODE_INT;
                    end
                end
                default: entry_o = ENT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/exc_pcsel.sv
module exc_pcsel
    import exc_pkg::*;
(
    input  entry_e          entry_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            dslot_i,
    input  logic            bev_i,
    input  logic [XLEN-1:0] ebase_i,
    output logic [XLEN-1:0] ret_pc_o,
    output logic [XLEN-1:0] vector_o
);
    assign ret_pc_o = dslot_i ? pc_i - XLEN'(INSN_BYTES) : pc_i;

    always_comb begin
        unique case (entry_i)
            ENT_GENERAL: vector_o = bev_i ? VEC_BOOTGEN : (ebase_i & ALIGN_MASK);
            ENT_ERROR:   vector_o = VEC_ERROR;
            ENT_DEBUG:   vector_o = VEC_DEBUG;
            default:     vector_o = '0;
        endcase
    end
endmodule

// File: rtl/exc_fault_fmt.sv
module exc_fault_fmt
    import exc_pkg::*;
(
    input  logic [XLEN-1:0]       addr_i,
    input  logic [ASID_W-1:0]     asid_i,
    input  logic [CTX_BASE_W-1:0] ctx_base_i,
    output logic [XLEN-1:0]       context_o,
    output logic [XLEN-1:0]       entryhi_o
);
    assign context_o = (XLEN'(ctx_base_i) << CTX_BASE_LSB) | ((addr_i >> CTX_SHIFT) & CTX_MASK);
    assign entryhi_o = (addr_i & VPN2_MASK) | XLEN'(asid_i);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  exc_req_i,
    input  logic [SRC_W-1:0]      exc_src_i,
    input  logic [CODE_W-1:0]     exc_code_i,
    input  logic [FKIND_W-1:0]    fault_kind_i,
    input  logic                  fault_wr_i,
    input  logic [XLEN-1:0]       fault_addr_i,
    input  logic [XLEN-1:0]       pc_i,
    input  logic                  in_dslot_i,
    input  logic                  exl_i,
    input  logic                  erl_i,
    input  logic                  bev_i,
    input  logic                  um_i,
    input  logic                  dm_i,
    input  logic [XLEN-1:0]       ebase_i,
    input  logic [ASID_W-1:0]     asid_i,
    input  logic [CTX_BASE_W-1:0] ctx_base_i,
    output logic                  redirect_o,
    output logic [XLEN-1:0]       redirect_pc_o,
    output logic [XLEN-1:0]       epc_o,
    output logic [XLEN-1:0]       errorepc_o,
    output logic [XLEN-1:0]       depc_o,
    output logic                  cause_bd_o,
    output logic [CODE_W-1:0]     cause_code_o,
    output logic                  exl_o,
    output logic                  erl_o,
    output logic                  bev_o,
    output logic                  um_o,
    output logic                  dm_o,
    output logic [XLEN-1:0]       badvaddr_o,
    output logic [XLEN-1:0]       context_o,
    output logic [XLEN-1:0]       entryhi_o
);
    entry_e            entry, entry_q;
    logic              wr_code, cap_fault;
    logic [CODE_W-1:0] cls_code;
    logic [XLEN-1:0]   ret_pc, vector, ctx_fmt, ehi_fmt;

    status_t           st_q, st_d;
    logic [XLEN-1:0]   epc_q, epc_d, errpc_q, errpc_d, depc_q, depc_d;
    logic [XLEN-1:0]   rpc_q, rpc_d, badv_q, badv_d, ctx_q, ctx_d, ehi_q, ehi_d;
    logic              bd_q, bd_d;
    logic [CODE_W-1:0] code_q, code_d;

    exc_classify u_cls (
        .req_i       (exc_req_i),
        .src_i       (exc_src_i),
        .dm_i        (dm_i),
        .code_i      (exc_code_i),
        .fkind_i     (fault_kind_i),
        .fwr_i       (fault_wr_i),
        .entry_o     (entry),
        .wr_code_o   (wr_code),
        .code_o      (cls_code),
        .cap_fault_o (cap_fault)
    );

    exc_pcsel u_pcs (
        .entry_i  (entry),
        .pc_i     (pc_i),
        .dslot_i  (in_dslot_i),
        .bev_i    (bev_i),
        .ebase_i  (ebase_i),
        .ret_pc_o (ret_pc),
        .vector_o (vector)
    );

    exc_fault_fmt u_fmt (
        .addr_i     (fault_addr_i),
        .asid_i     (asid_i),
        .ctx_base_i (ctx_base_i),
        .context_o  (ctx_fmt),
        .entryhi_o  (ehi_fmt)
    );

    // State register: last entry class plus all held registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q <= ENT_NONE;
            st_q    <= '{exl: 1'b0, erl: 1'b1, bev: 1'b1, um: 1'b0, dm: 1'b0};
            epc_q   <= '0;
            errpc_q <= '0;
            depc_q  <= '0;
            rpc_q   <= '0;
            badv_q  <= '0;
            ctx_q   <= '0;
            ehi_q   <= '0;
            bd_q    <= 1'b0;
            code_q  <= '0;
        end else begin
            entry_q <= entry;
            st_q    <= st_d;
            epc_q   <= epc_d;
            errpc_q <= errpc_d;
            depc_q  <= depc_d;
            rpc_q   <= rpc_d;
            badv_q  <= badv_d;
            ctx_q   <= ctx_d;
            ehi_q   <= ehi_d;
            bd_q    <= bd_d;
            code_q  <= code_d;
        end
    end

    // Next-value process per entry class.
    always_comb begin
        st_d    = '{exl: exl_i, erl: erl_i, bev: bev_i, um: um_i, dm: dm_i};
        epc_d   = epc_q;
        errpc_d = errpc_q;
        depc_d  = depc_q;
        rpc_d   = rpc_q;
        bd_d    = bd_q;
        code_d  = wr_code ? cls_code : code_q;
        unique case (entry)
            ENT_GENERAL: begin
                if (!exl_i) begin
                    epc_d = ret_pc;
                    bd_d  = in_dslot_i;
                end
                st_d.exl = 1'b1;
                st_d.um  = 1'b0;
                rpc_d    = vector;
            end
            ENT_ERROR: begin
                errpc_d  = ret_pc;
                if (!exl_i) bd_d = 1'b0;
                st_d.erl = 1'b1;
                st_d.bev = 1'b1;
                st_d.um  = 1'b0;
                rpc_d    = vector;
            end
            ENT_DEBUG: begin
                depc_d  = ret_pc;
                if (!exl_i) bd_d = 1'b0;
                st_d.dm = 1'b1;
                st_d.um = 1'b0;
                rpc_d   = vector;
            end
            default: ;
        endcase
        badv_d = cap_fault ? fault_addr_i : badv_q;
        ctx_d  = cap_fault ? ctx_fmt      : ctx_q;
        ehi_d  = cap_fault ? ehi_fmt      : ehi_q;
    end

    assign redirect_o    = (entry_q != ENT_NONE);
    assign redirect_pc_o = rpc_q;
    assign epc_o         = epc_q;
    assign errorepc_o    = errpc_q;
    assign depc_o        = depc_q;
    assign cause_bd_o    = bd_q;
    assign cause_code_o  = code_q;
    assign exl_o         = st_q.exl;
    assign erl_o         = st_q.erl;
    assign bev_o         = st_q.bev;
    assign um_o          = st_q.um;
    assign dm_o          = st_q.dm;
    assign badvaddr_o    = badv_q;
    assign context_o     = ctx_q;
    assign entryhi_o     = ehi_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        exc_req_i,
    input logic [2:0]  exc_src_i,
    input logic [31:0] pc_i,
    input logic        in_dslot_i,
    input logic        exl_i,
    input logic        dm_i,
    input logic        redirect_o,
    input logic [31:0] redirect_pc_o,
    input logic [31:0] epc_o,
    input logic        cause_bd_o,
    input logic        exl_o,
    input logic        erl_o,
    input logic        bev_o,
    input logic        um_o,
    input logic        dm_o
);
    a_r1_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_i && exc_src_i == 3'd0 && !exl_i |=>
            epc_o == ($past(in_dslot_i) ? $past(pc_i) - 32'd4 : $past(pc_i))
            && cause_bd_o == $past(in_dslot_i) && exl_o && !um_o);

    a_r2_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_i && exc_src_i == 3'd0 && exl_i |=>
            epc_o == $past(epc_o) && cause_bd_o == $past(cause_bd_o) && exl_o);

    a_r5_error_entry: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_i && exc_src_i == 3'd2 |=>
            redirect_o && redirect_pc_o == 32'hBFC0_0000 && erl_o && bev_o && !um_o);

    a_r6_debug_entry: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_i && exc_src_i == 3'd3 |=>
            redirect_o && redirect_pc_o == 32'hBFC0_0480 && dm_o && !um_o);

    a_r7_dint_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_i && exc_src_i == 3'd4 && dm_i |=> redirect_pc_o == 32'hBFC0_0480 && dm_o);

    a_r10_strobe_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_i && exc_src_i <= 3'd4 |=> redirect_o);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_req_i && exc_src_i <= 3'd4) |=> !redirect_o);
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .exc_req_i     (exc_req_i),
    .exc_src_i     (exc_src_i),
    .pc_i          (pc_i),
    .in_dslot_i    (in_dslot_i),
    .exl_i         (exl_i),
    .dm_i          (dm_i),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .epc_o         (epc_o),
    .cause_bd_o    (cause_bd_o),
    .exl_o         (exl_o),
    .erl_o         (erl_o),
    .bev_o         (bev_o),
    .um_o          (um_o),
    .dm_o          (dm_o)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
    localparam int CYC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req_i = 1'b0;
    logic [2:0]  exc_src_i = '0;
    logic [4:0]  exc_code_i = '0;
    logic [1:0]  fault_kind_i = '0;
    logic        fault_wr_i = 1'b0;
    logic [31:0] fault_addr_i = '0;
    logic [31:0] pc_i = '0;
    logic        in_dslot_i = 1'b0;
    logic        exl_i = 1'b0, erl_i = 1'b0, bev_i = 1'b0, um_i = 1'b0, dm_i = 1'b0;
    logic [31:0] ebase_i = '0;
    logic [7:0]  asid_i = '0;
    logic [8:0]  ctx_base_i = '0;

    logic        redirect_o;
    logic [31:0] redirect_pc_o, epc_o, errorepc_o, depc_o;
    logic        cause_bd_o;
    logic [4:0]  cause_code_o;
    logic        exl_o, erl_o, bev_o, um_o, dm_o;
    logic [31:0] badvaddr_o, context_o, entryhi_o;

    int n_vec = 0;
    int n_bad = 0;

    // reference state
    logic [31:0] m_epc = '0, m_err = '0, m_depc = '0, m_badv = '0, m_ctx = '0, m_ehi = '0;
    logic        m_bd = 1'b0;
    logic [4:0]  m_code = '0;

    always #(CYC/2) clk = ~clk;

    exc_entry_ctrl u0 (.*);

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One vector: inputs already set; predict, clock, compare.
    task automatic apply();
        int          kind;  // 0 none, 1 general, 2 error, 3 debug
        logic [31:0] rp, vec;
        logic        e_exl, e_erl, e_bev, e_um, e_dm;
        string       tag;
        kind = 0;
        tag  = "R11";
        rp   = in_dslot_i ? pc_i - 32'd4 : pc_i;
        e_exl = exl_i; e_erl = erl_i; e_bev = bev_i; e_um = um_i; e_dm = dm_i;
        vec = 32'h0;
        if (exc_req_i) begin
            case (exc_src_i)
                3'd0: begin kind = 1; m_code = exc_code_i; tag = exl_i ? "R2" : "R1"; end
                3'd1: begin
                    kind = 1; tag = "R8";
                    if (fault_kind_i == 2'd2) m_code = 5'd1;
                    else if (fault_kind_i == 2'd3) m_code = fault_wr_i ? 5'd5 : 5'd4;
                    else m_code = fault_wr_i ? 5'd3 : 5'd2;
                    m_badv = fault_addr_i;
                    m_ctx  = ({23'd0, ctx_base_i} << 23) | ((fault_addr_i >> 9) & 32'h007F_FFF0);
                    m_ehi  = {24'd0, asid_i} | (fault_addr_i & 32'hFFFF_E000);
                end
                3'd2: begin kind = 2; tag = "R5"; end
                3'd3: begin kind = 3; tag = "R6"; end
                3'd4: if (dm_i) begin kind = 3; tag = "R7"; end
                      else begin kind = 1; m_code = 5'd0; tag = "R4"; end
                default: tag = "R10";
            endcase
        end
        if (kind == 1) begin
            if (!exl_i) begin m_epc = rp; m_bd = in_dslot_i; end
            e_exl = 1'b1; e_um = 1'b0;
            vec = bev_i ? 32'hBFC0_0200 : {ebase_i[31:10], 10'd0};
        end else if (kind == 2) begin
            m_err = rp; if (!exl_i) m_bd = 1'b0;
            e_erl = 1'b1; e_bev = 1'b1; e_um = 1'b0;
            vec = 32'hBFC0_0000;
        end else if (kind == 3) begin
            m_depc = rp; if (!exl_i) m_bd = 1'b0;
            e_dm = 1'b1; e_um = 1'b0;
            vec = 32'hBFC0_0480;
        end
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        chk("R10", "redirect", {31'd0, redirect_o}, {31'd0, kind != 0});
        if (kind != 0) chk(kind == 1 ? "R3" : tag, "redirect_pc", redirect_pc_o, vec);
        chk(tag, "epc", epc_o, m_epc);
        chk(tag, "errorepc", errorepc_o, m_err);
        chk(tag, "depc", depc_o, m_depc);
        chk(tag, "bd", {31'd0, cause_bd_o}, {31'd0, m_bd});
        chk(tag, "code", {27'd0, cause_code_o}, {27'd0, m_code});
        chk(tag, "status", {27'd0, exl_o, erl_o, bev_o, um_o, dm_o},
            {27'd0, e_exl, e_erl, e_bev, e_um, e_dm});
        chk("R9", "badvaddr", badvaddr_o, m_badv);
        chk("R9", "context", context_o, m_ctx);
        chk("R9", "entryhi", entryhi_o, m_ehi);
    endtask

    task automatic setv(input logic req, input logic [2:0] src, input logic [31:0] pc,
                        input logic ds, input logic exl, input logic bev, input logic dm);
        exc_req_i = req; exc_src_i = src; pc_i = pc; in_dslot_i = ds;
        exl_i = exl; bev_i = bev; dm_i = dm; um_i = 1'b1; erl_i = 1'b0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        ebase_i = 32'h8000_1234; asid_i = 8'h5A; ctx_base_i = 9'h1A5;
        exc_code_i = 5'd9; fault_addr_i = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R12 reset state, sampled while reset is held
        n_vec++;
        chk("R12", "redirect", {31'd0, redirect_o}, 32'd0);
        chk("R12", "status", {27'd0, exl_o, erl_o, bev_o, um_o, dm_o}, 32'b01100);
        chk("R12", "epc", epc_o, 32'd0);
        chk("R12", "code", {27'd0, cause_code_o}, 32'd0);
        chk("R12", "context", context_o, 32'd0);
        rst_n = 1'b1;

        // R1 delay slot, R3 base vector with low bits cleared
        setv(1, 3'd0, 32'h0040_0104, 1, 0, 0, 0); apply();
        // R2 EXL set: EPC and BD keep, code changes
        exc_code_i = 5'd12;
        setv(1, 3'd0, 32'h0040_0900, 0, 1, 1, 0); apply();
        // R3 boot vector, no delay slot
        setv(1, 3'd0, 32'h0040_0200, 0, 0, 1, 0); apply();
        // R8/R9 all fault kinds, both directions
        for (int k = 0; k < 8; k++) begin
            fault_kind_i = k[1:0]; fault_wr_i = k[2];
            fault_addr_i = 32'hC0DE_0000 + (k << 13) + 32'h5A5;
            setv(1, 3'd1, 32'h0041_0000, k[0], 0, 0, 0); apply();
        end
        // R5 error entry in delay slot
        setv(1, 3'd2, 32'h8000_0010, 1, 0, 0, 0); apply();
        // R6 debug entry
        setv(1, 3'd3, 32'h8000_0020, 1, 1, 0, 0); apply();
        // R7 interrupt in debug mode; R4 interrupt outside
        setv(1, 3'd4, 32'h8000_0030, 0, 0, 0, 1); apply();
        setv(1, 3'd4, 32'h8000_0040, 0, 0, 0, 0); apply();
        // R10 unused source codes
        setv(1, 3'd6, 32'hDEAD_0000, 1, 0, 0, 0); apply();
        setv(1, 3'd7, 32'hDEAD_0004, 0, 0, 0, 0); apply();
        // R11 idle
        setv(0, 3'd0, 32'hDEAD_0008, 1, 1, 1, 1); apply();

        for (int i = 0; i < 600; i++) begin
            exc_req_i    = ($urandom % 6) != 0;
            exc_src_i    = 3'($urandom_range(0, 7));
            exc_code_i   = 5'($urandom);
            fault_kind_i = 2'($urandom);
            fault_wr_i   = 1'($urandom);
            fault_addr_i = $urandom;
            pc_i         = $urandom & 32'hFFFF_FFFC;
            in_dslot_i   = 1'($urandom);
            exl_i = 1'($urandom); erl_i = 1'($urandom); bev_i = 1'($urandom);
            um_i  = 1'($urandom); dm_i  = 1'($urandom);
            ebase_i = $urandom; asid_i = 8'($urandom); ctx_base_i = 9'($urandom);
            apply();
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CYC * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule